// File: doc/BRIEF.md
# TLB Configuration Command Controller

This block is the control state machine between a bus-slave front end and a sixteen-entry translation lookaside buffer inside a memory management unit. It waits for the front end to pull its ready strobe low. It then sorts the presented address and data into one of four classes: a mode switch, a TLB clear, a forbidden access that must raise a page fault, or a normal read or write of one TLB entry. Each class produces a short, fixed pulse pattern on the outputs, and the controller then goes back to waiting.

A mode switch or a TLB clear is requested by presenting the same ASCII word on both the address and the data inputs. "ON" is 0x4F4E, "OFF" is 0x4F4646 and "RST" is 0x525354, each zero-extended to the input width. A TLB access is allowed only in system mode and only for an address whose virtual-space bit is set. Any other access becomes a one-cycle page-fault pulse. The controller captures the address, data and direction when a command starts, so the front end may change those inputs while the command runs.

Top module: `tlbcfg_ctrl`

## Requirements
- R1: During and directly after reset, the outputs show idle values: mode_en_o=0, mode_val_o=0, tlb_rst_n_o=1, fault_o=0, tlb_en_o=0, tlb_wr_o=0, tlb_idx_o=0 and tlb_data_o=0.
- R2: A command starts only on a clock edge where the controller is idle, ready_in is sampled low and ready_in was sampled high on the previous edge. Keeping ready_in high, or keeping it low after a command, starts nothing. A falling edge of ready_in while a command is still running is ignored.
- R3: When addr_in and data_in both equal 0x4F4E, mode_en_o=1 and mode_val_o=1 (user mode) for exactly the one cycle after the start edge.
- R4: When addr_in and data_in both equal 0x4F4646, mode_en_o=1 and mode_val_o=0 (system mode) for exactly the one cycle after the start edge.
- R5: When addr_in and data_in both equal 0x525354, tlb_rst_n_o=0 for exactly the one cycle after the start edge.
- R6: A magic word on only one of the two inputs, or two different magic words, is not a command. It is handled as a fault or as an access.
- R7: Decoding priority is mode command, then clear command, then fault check, then access. A command is accepted even in user mode.
- R8: A non-command with user_mode_in=1, or with addr_in bit 26 clear, raises fault_o for exactly the one cycle after the start edge. It produces no TLB activity.
- R9: Any other start gives tlb_en_o=1 for exactly two cycles, with tlb_idx_o=addr_in[3:0]. In the second cycle tlb_wr_o equals the captured write_in. tlb_wr_o is 0 at all other times.
- R10: While tlb_en_o is high, tlb_data_o is {addr_in[25:10], data_in[15:0]} for a write and 0 for a read. The values come from the start edge, even if the inputs change afterwards.
- R11: After every command the controller returns to idle, and all outputs take their R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ready_in | input | 1 | Front-end strobe; a high-to-low transition starts a command |
| write_in | input | 1 | 1 = write access, 0 = read access |
| user_mode_in | input | 1 | Current mode: 1 = user, 0 = system |
| addr_in | input | 27 | Address from the front end; bit 26 marks virtual space |
| data_in | input | 32 | Write data or command word |
| mode_val_o | output | 1 | Requested mode, valid while mode_en_o is high |
| mode_en_o | output | 1 | Load enable for the external mode register |
| tlb_rst_n_o | output | 1 | TLB clear, active low |
| fault_o | output | 1 | Page-fault pulse |
| tlb_en_o | output | 1 | TLB enable, active high |
| tlb_wr_o | output | 1 | TLB write strobe in the second access cycle |
| tlb_idx_o | output | 4 | TLB entry index |
| tlb_data_o | output | 32 | Entry word for the TLB |

## Verification
The assertions check on every cycle that at most one of mode_en_o, fault_o, TLB clear and tlb_en_o is active. They also check that the mode, clear and fault pulses last one cycle, that tlb_en_o lasts exactly two, and that tlb_wr_o appears only in the second of those cycles. They further check that no output activity begins unless ready_in was low on the previous edge, and that a fault follows only a user-mode or non-virtual request. Only the bench sweeps can show the following: the class chosen for each combination of magic words, mode, direction and virtual bit; the exact index and entry word; and the capture of inputs at the start edge. The same holds for ignoring a strobe that is held low or arrives while a command is running.

// File: rtl/tlbcfg_pkg.sv
// Package: shared state and command types for the TLB configuration controller.
// Assumes the magic words fit in the narrowest input (27 bits).
package tlbcfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_MODE  = 3'd1,
        ST_CLR   = 3'd2,
        ST_FAULT = 3'd3,
        ST_RW    = 3'd4,
        ST_BUSY  = 3'd5
    } ctl_state_e;

    typedef enum logic [2:0] {
        CMD_GO_USER   = 3'd0,
        CMD_GO_SYSTEM = 3'd1,
        CMD_CLEAR     = 3'd2,
        CMD_FAULT     = 3'd3,
        CMD_ACCESS    = 3'd4
    } cmd_kind_e;

    localparam logic [31:0] WORD_ON  = 32'h0000_4F4E;
    localparam logic [31:0] WORD_OFF = 32'h004F_4646;
    localparam logic [31:0] WORD_RST = 32'h0052_5354;

endpackage

// File: rtl/tlbcfg_decode.sv
// Module: classifies the current address/data/mode into one command kind.
// Purely combinational; priority is mode word, clear word, fault check, access.
// Assumes magic words are compared zero-extended to the input widths.
module tlbcfg_decode
    import tlbcfg_pkg::*;
#(
    parameter int ADDR_W   = 27,
    parameter int DATA_W   = 32,
    parameter int VIRT_BIT = 26
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              user_mode_in,
    output cmd_kind_e         kind_o
);

    logic is_on, is_off, is_rst;

    // Match each magic word on both inputs at once.
    always_comb begin
        is_on  = (addr_in == ADDR_W'(WORD_ON))  && (data_in == DATA_W'(WORD_ON));
        is_off = (addr_in == ADDR_W'(WORD_OFF)) && (data_in == DATA_W'(WORD_OFF));
        is_rst = (addr_in == ADDR_W'(WORD_RST)) && (data_in == DATA_W'(WORD_RST));
    end

    // Resolve the command kind in priority order.
    always_comb begin
        if (is_on)
            kind_o = CMD_GO_USER;
        else if (is_off)
            kind_o = CMD_GO_SYSTEM;
        else if (is_rst)
            kind_o = CMD_CLEAR;
        else if (user_mode_in || !addr_in[VIRT_BIT])
            kind_o = CMD_FAULT;
        else
            kind_o = CMD_ACCESS;
    end

endmodule

// File: rtl/tlbcfg_fsm.sv
// Module: sequencing state machine plus capture of the request at its start.
// A request starts only in idle on a high-to-low transition of ready_in.
// Assumes an asynchronous active-low reset.
module tlbcfg_fsm
    import tlbcfg_pkg::*;
#(
    parameter int ADDR_W = 27,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready_in,
    input  logic              write_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  cmd_kind_e         kind_i,
    output ctl_state_e        state_o,
    output logic              user_sel_o,
    output logic              wr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);

    ctl_state_e state_q, state_d;
    logic       ready_q;
    logic       start;

    // Detect the start condition from the previous ready sample.
    always_comb start = (state_q == ST_IDLE) && ready_q && !ready_in;

    // Choose the next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    unique case (kind_i)
                        CMD_GO_USER, CMD_GO_SYSTEM: state_d = ST_MODE;
                        CMD_CLEAR:                  state_d = ST_CLR;
                        CMD_FAULT:                  state_d = ST_FAULT;
                        default:                    state_d = ST_RW;
                    endcase
                end
            end
            ST_RW:   state_d = ST_BUSY;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and ready history.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ready_q <= 1'b1;
        end else begin
            state_q <= state_d;
            ready_q <= ready_in;
        end
    end

    // Capture the request fields on the start edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            user_sel_o <= 1'b0;
            wr_o       <= 1'b0;
            addr_o     <= '0;
            data_o     <= '0;
        end else if (start) begin
            user_sel_o <= (kind_i == CMD_GO_USER);
            wr_o       <= write_in;
            addr_o     <= addr_in;
            data_o     <= data_in;
        end
    end

    always_comb state_o = state_q;

endmodule

// File: rtl/tlbcfg_outmux.sv
// Module: derives all outputs from the state and the captured request.
// Every strobe is inactive and index/data are zero outside their states.
// Assumes VIRT_BIT >= VPN_W so the virtual page slice lies below the flag.
module tlbcfg_outmux
    import tlbcfg_pkg::*;
#(
    parameter int ADDR_W   = 27,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 4,
    parameter int PAY_W    = 16,
    parameter int VIRT_BIT = 26
) (
    input  ctl_state_e        state_i,
    input  logic              user_sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              mode_val_o,
    output logic              mode_en_o,
    output logic              tlb_rst_n_o,
    output logic              fault_o,
    output logic              tlb_en_o,
    output logic              tlb_wr_o,
    output logic [IDX_W-1:0]  tlb_idx_o,
    output logic [DATA_W-1:0] tlb_data_o
);

    localparam int VPN_W = DATA_W - PAY_W;

    logic              in_access;
    logic [DATA_W-1:0] entry_word;

    // Join the virtual page from the address with the payload from the data.
    always_comb entry_word = {addr_i[VIRT_BIT-1 -: VPN_W], data_i[PAY_W-1:0]};

    // Decode state into the output strobes and buses.
    always_comb begin
        in_access   = (state_i == ST_RW) || (state_i == ST_BUSY);
        mode_en_o   = (state_i == ST_MODE);
        mode_val_o  = (state_i == ST_MODE) && user_sel_i;
        tlb_rst_n_o = (state_i != ST_CLR);
        fault_o     = (state_i == ST_FAULT);
        tlb_en_o    = in_access;
        tlb_wr_o    = (state_i == ST_BUSY) && wr_i;
        tlb_idx_o   = in_access ? addr_i[IDX_W-1:0] : '0;
        tlb_data_o  = (in_access && wr_i) ? entry_word : '0;
    end

endmodule

// File: rtl/tlbcfg_ctrl.sv
// Module: top of the TLB configuration controller.
// Takes a start strobe from a bus-slave front end and turns the request into
// mode, clear, fault or TLB access pulses. Assumes the mode register and the
// TLB storage are outside and react to the strobes on the next edge.
module tlbcfg_ctrl
    import tlbcfg_pkg::*;
#(
    parameter int ADDR_W   = 27,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 4,
    parameter int PAY_W    = 16,
    parameter int VIRT_BIT = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready_in,
    input  logic              write_in,
    input  logic              user_mode_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              mode_val_o,
    output logic              mode_en_o,
    output logic              tlb_rst_n_o,
    output logic              fault_o,
    output logic              tlb_en_o,
    output logic              tlb_wr_o,
    output logic [IDX_W-1:0]  tlb_idx_o,
    output logic [DATA_W-1:0] tlb_data_o
);

    cmd_kind_e         kind;
    ctl_state_e        state;
    logic              user_sel;
    logic              wr_cap;
    logic [ADDR_W-1:0] addr_cap;
    logic [DATA_W-1:0] data_cap;

    tlbcfg_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VIRT_BIT(VIRT_BIT)
    ) u_decode (
        .addr_in(addr_in), .data_in(data_in),
        .user_mode_in(user_mode_in), .kind_o(kind)
    );

    tlbcfg_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .ready_in(ready_in), .write_in(write_in),
        .addr_in(addr_in), .data_in(data_in), .kind_i(kind),
        .state_o(state), .user_sel_o(user_sel), .wr_o(wr_cap),
        .addr_o(addr_cap), .data_o(data_cap)
    );

    tlbcfg_outmux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
        .PAY_W(PAY_W), .VIRT_BIT(VIRT_BIT)
    ) u_out (
        .state_i(state), .user_sel_i(user_sel), .wr_i(wr_cap),
        .addr_i(addr_cap), .data_i(data_cap),
        .mode_val_o(mode_val_o), .mode_en_o(mode_en_o),
        .tlb_rst_n_o(tlb_rst_n_o), .fault_o(fault_o),
        .tlb_en_o(tlb_en_o), .tlb_wr_o(tlb_wr_o),
        .tlb_idx_o(tlb_idx_o), .tlb_data_o(tlb_data_o)
    );

endmodule

// File: rtl/tlbcfg_ctrl_chk.sv
// Module: property checker for tlbcfg_ctrl, attached to it by bind.
// Watches only the top-level ports.
module tlbcfg_ctrl_chk #(
    parameter int ADDR_W   = 27,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = 4,
    parameter int VIRT_BIT = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready_in,
    input logic              user_mode_in,
    input logic [ADDR_W-1:0] addr_in,
    input logic              mode_en_o,
    input logic              tlb_rst_n_o,
    input logic              fault_o,
    input logic              tlb_en_o,
    input logic              tlb_wr_o
);

    logic any_act;
    always_comb any_act = mode_en_o | fault_o | ~tlb_rst_n_o | tlb_en_o;

    // R7: only one class of activity at a time.
    assert_one_class_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mode_en_o, fault_o, ~tlb_rst_n_o, tlb_en_o}));

    // R3, R4: the mode enable lasts one cycle.
    assert_mode_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_en_o |=> !mode_en_o);

    // R5: the TLB clear lasts one cycle.
    assert_clear_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tlb_rst_n_o |=> tlb_rst_n_o);

    // R8: the fault lasts one cycle.
    assert_fault_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> !fault_o);

    // R8: a fault follows only a user-mode or non-virtual request.
    assert_fault_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> $past(user_mode_in || !addr_in[VIRT_BIT]));

    // R9: the access enable lasts two cycles.
    assert_access_two_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tlb_en_o) |=> tlb_en_o);
    assert_access_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_en_o && $past(tlb_en_o)) |=> !tlb_en_o);

    // R9: the write strobe appears only in the second access cycle.
    assert_write_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_wr_o |-> (tlb_en_o && $past(tlb_en_o)));

    // R2: activity starts only after ready_in was sampled low.
    assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_act) |-> $past(!ready_in));

endmodule

bind tlbcfg_ctrl tlbcfg_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .VIRT_BIT(VIRT_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ready_in(ready_in),
    .user_mode_in(user_mode_in), .addr_in(addr_in),
    .mode_en_o(mode_en_o), .tlb_rst_n_o(tlb_rst_n_o), .fault_o(fault_o),
    .tlb_en_o(tlb_en_o), .tlb_wr_o(tlb_wr_o)
);

// File: tb/tb_tlbcfg_ctrl.sv
// Bench: sweeps command words, modes, directions, virtual bit and all indices.
module tb_tlbcfg_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ready_in = 1'b1;
    logic        write_in = 1'b0;
    logic        user_mode_in = 1'b0;
    logic [26:0] addr_in = '0;
    logic [31:0] data_in = '0;
    logic        mode_val_o, mode_en_o, tlb_rst_n_o, fault_o, tlb_en_o, tlb_wr_o;
    logic [3:0]  tlb_idx_o;
    logic [31:0] tlb_data_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    localparam logic [41:0] IDLE_V = {6'b001000, 4'h0, 32'h0};

    always #2.5 clk = ~clk;

    tlbcfg_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ready_in(ready_in), .write_in(write_in),
        .user_mode_in(user_mode_in), .addr_in(addr_in), .data_in(data_in),
        .mode_val_o(mode_val_o), .mode_en_o(mode_en_o),
        .tlb_rst_n_o(tlb_rst_n_o), .fault_o(fault_o), .tlb_en_o(tlb_en_o),
        .tlb_wr_o(tlb_wr_o), .tlb_idx_o(tlb_idx_o), .tlb_data_o(tlb_data_o)
    );

    function automatic logic [41:0] outs();
        return {mode_en_o, mode_val_o, tlb_rst_n_o, fault_o, tlb_en_o,
                tlb_wr_o, tlb_idx_o, tlb_data_o};
    endfunction

    task automatic chk(input string req, input logic [41:0] exp);
        checks++;
        if (outs() !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, outs(), exp);
        end
    endtask

    // One request; the expected pattern is worked out from R3..R11.
    task automatic run_req(input logic [26:0] a, input logic [31:0] d,
                           input logic wr, input logic um);
        logic [41:0] e1, e2;
        string req;
        @(negedge clk);
        ready_in = 1'b1;
        @(negedge clk);
        addr_in = a; data_in = d; write_in = wr; user_mode_in = um;
        ready_in = 1'b0;
        e2 = IDLE_V;
        if (a == 27'h4F4E && d == 32'h4F4E) begin
            e1 = {6'b111000, 4'h0, 32'h0}; req = "R3";
        end else if (a == 27'h4F4646 && d == 32'h4F4646) begin
            e1 = {6'b101000, 4'h0, 32'h0}; req = "R4";
        end else if (a == 27'h525354 && d == 32'h525354) begin
            e1 = {6'b000000, 4'h0, 32'h0}; req = "R5";
        end else if (um || !a[26]) begin
            e1 = {6'b001100, 4'h0, 32'h0}; req = "R8";
        end else begin
            e1 = {6'b001010, a[3:0], wr ? {a[25:10], d[15:0]} : 32'h0};
            e2 = {5'b00101, wr, a[3:0], wr ? {a[25:10], d[15:0]} : 32'h0};
            req = "R9/R10";
        end
        @(negedge clk);
        chk(req, e1);
        // Scramble inputs: the captured request must hold (R10).
        addr_in = ~a; data_in = ~d; write_in = ~wr;
        @(negedge clk);
        chk(req, e2);
        @(negedge clk);
        chk("R11", IDLE_V);
    endtask

    initial begin
        #50000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got hang expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: idle values in and after reset
        repeat (3) @(negedge clk);
        chk("R1", IDLE_V);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", IDLE_V);

        // R2: ready held high with a valid access pattern does nothing
        addr_in = 27'h400_0005; write_in = 1'b1; data_in = 32'h1234;
        repeat (3) begin
            @(negedge clk);
            chk("R2", IDLE_V);
        end

        // R3, R4, R5, R7: commands in both modes
        for (int um = 0; um < 2; um++) begin
            run_req(27'h4F4E, 32'h4F4E, 1'b0, um[0]);
            run_req(27'h4F4646, 32'h4F4646, 1'b1, um[0]);
            run_req(27'h525354, 32'h525354, 1'b0, um[0]);
        end

        // R6: partial or mixed magic words
        run_req(27'h4F4E, 32'h4F4646, 1'b0, 1'b0);
        run_req(27'h525354, 32'h0, 1'b0, 1'b0);
        run_req(27'h4F4E | 27'h400_0000, 32'h4F4E, 1'b1, 1'b0);

        // R8, R9, R10: full index sweep by mode, direction and virtual bit
        for (int i = 0; i < 16; i++)
            for (int w = 0; w < 2; w++)
                for (int u = 0; u < 2; u++)
                    for (int v = 0; v < 2; v++)
                        run_req({v[0], 16'(i * 16'h0F1D + 7), 6'(i * 3), i[3:0]},
                                32'hA5C3_0000 ^ (i * 32'h0101_0707),
                                w[0], u[0]);

        // R2: ready held low after a command starts nothing more
        run_req(27'h400_0A03, 32'h0000_BEEF, 1'b1, 1'b0);
        repeat (3) begin
            @(negedge clk);
            chk("R2", IDLE_V);
        end

        // R2: falling edge during the busy cycle is ignored
        @(negedge clk);
        ready_in = 1'b1;
        @(negedge clk);
        addr_in = 27'h400_0009; data_in = 32'h77; write_in = 1'b1;
        user_mode_in = 1'b0; ready_in = 1'b0;
        @(negedge clk);
        ready_in = 1'b1;
        addr_in = 27'h4F4E; data_in = 32'h4F4E;
        @(negedge clk);
        ready_in = 1'b0;
        @(negedge clk);
        chk("R2", IDLE_V);
        @(negedge clk);
        chk("R2", IDLE_V);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule